// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block is a down-counter that runs on a slow tick strobe, nominally 32768 pulses per second, and raises an interrupt at a fixed rate. Software writes a reload value and then sets an enable bit. From that point the counter steps down by one on each tick. When it expires it reloads from the stored value and sets a pending flag. To get a wanted interrupt rate, software writes the tick frequency divided by that rate as the reload value. The reload value cannot be changed while the timer runs. Software reads the live count through the same register bus.

The pending flag is bit 1 of an interrupt register group that the block shares with its neighbours: a mask, a raw status, a masked status and a write-one-to-clear word. Bit 1 is the only bit this block drives; every other bit of that group reads as zero. The bus is a simple 32-bit read/write port. Read data comes out of a register one cycle after the read request. The tick input is assumed to be already synchronous to the bus clock.

Top module: `pit_timer`

## Requirements
- R1: After synchronous reset the count, reload value, control word, raw flag, mask, irq output and read data are all zero.
- R2: A write to the reload register (0x24) while the timer is disabled stores the value, and a read of 0x24 returns it.
- R3: A write to the reload register while the enable bit is set is ignored, and the stored value is unchanged.
- R4: Control register 0x28 bit 1 is the enable bit and reads back as written, with all other bits reading 0. Writing 1 to it while it is 0 copies the reload value into the count. Writing 1 while it is already 1 leaves the count alone.
- R5: While the timer is enabled and the reload value is nonzero, each tick decrements the count (read at 0x20) by one. Cycles without a tick leave the count unchanged.
- R6: A tick that finds the count at 1 (or 0) with a nonzero reload value instead reloads the count and sets the raw flag. This gives one expiry every reload-value ticks.
- R7: With a reload value of 0, ticks never expire and the count stays at 0.
- R8: While the timer is disabled the count holds its last value regardless of ticks.
- R9: Mask bit 1 lives at 0x10. Raw status at 0x14 and masked status at 0x18 report the flag in bit 1, and the masked status is raw AND mask. The irq output equals the masked status delayed by one register stage.
- R10: Writing a word with bit 1 set to 0x1c clears the raw flag, and a word with bit 1 clear has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R11: Read data appears in the cycle after the read request. An unmapped address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count strobe at the slow tick rate |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered masked interrupt |

## Verification
Two events can land in the same clock: an expiry that sets the raw flag, and a software clear of that flag. To provoke this, the bench runs the count down to 1 and then drives a tick and a clear write in one cycle. It judges the outcome by reading the raw status, which must still show bit 1 set. Plain clears and clear words without bit 1 are checked separately, so that set-priority cannot hide a dead clear path. Each reload value from 0 to 6 is swept over more than two periods, and after every tick the count and flag are compared with an arithmetic model.

// File: rtl/pit_pkg.sv
package pit_pkg;
  // register byte offsets; the interrupt group is shared with neighbour blocks
  localparam int OFS_MASK   = 'h10;
  localparam int OFS_RAW    = 'h14;
  localparam int OFS_MASKED = 'h18;
  localparam int OFS_CLEAR  = 'h1c;
  localparam int OFS_COUNT  = 'h20;
  localparam int OFS_RELOAD = 'h24;
  localparam int OFS_CTRL   = 'h28;
  // bit of the shared interrupt group owned by this timer
  localparam int IRQ_BIT    = 1;
  // enable bit inside the control word
  localparam int RUN_BIT    = 1;
endpackage

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             start,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic armed;

  always_comb begin
    armed  = run && !start && tick && (reload != '0);
    expire = armed && (count <= CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (start) begin
      count <= reload;
    end else if (armed) begin
      if (count <= CNT_W'(1)) count <= reload;
      else                     count <= count - CNT_W'(1);
    end
  end

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !start && tick && reload != '0 && count > CNT_W'(1))
      |=> count == $past(count) - CNT_W'(1));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(count));
endmodule

// File: rtl/pit_irq.sv
module pit_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic mask_we,
  input  logic mask_d,
  output logic raw,
  output logic mask,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw  <= 1'b0;
      mask <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (set)      raw  <= 1'b1;
      else if (clr) raw  <= 1'b0;
      if (mask_we)  mask <= mask_d;
      irq <= raw && mask;
    end
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> raw);

  // R10
  clear_works_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !raw);
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import pit_pkg::*;

  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

  logic             run;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;
  logic             expire;
  logic             start;
  logic             raw, mask;
  logic             we_ctrl, we_reload, we_mask, we_clear;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    we_ctrl   = bus_wr && (bus_addr == A_CTRL);
    we_reload = bus_wr && (bus_addr == A_RELOAD);
    we_mask   = bus_wr && (bus_addr == A_MASK);
    we_clear  = bus_wr && (bus_addr == A_CLEAR) && bus_wdata[IRQ_BIT];
    start     = we_ctrl && bus_wdata[RUN_BIT] && !run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      reload_q <= '0;
    end else begin
      if (we_ctrl)           run      <= bus_wdata[RUN_BIT];
      if (we_reload && !run) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .run    (run),
    .start  (start),
    .reload (reload_q),
    .count  (count),
    .expire (expire)
  );

  pit_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .set     (expire),
    .clr     (we_clear),
    .mask_we (we_mask),
    .mask_d  (bus_wdata[IRQ_BIT]),
    .raw     (raw),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_MASK:   rd_mux[IRQ_BIT] = mask;
      A_RAW:    rd_mux[IRQ_BIT] = raw;
      A_MASKED: rd_mux[IRQ_BIT] = raw && mask;
      A_COUNT:  rd_mux = DATA_W'(count);
      A_RELOAD: rd_mux = DATA_W'(reload_q);
      A_CTRL:   rd_mux[RUN_BIT] = run;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R3
  reload_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (we_reload && run) |=> $stable(reload_q));

  // R4
  start_copy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (run && count == $past(reload_q)));

  // R7
  zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (run && reload_q == '0 && !raw && !we_reload) |=> !raw);
endmodule

// File: tb/sim_pit_timer.sv
module sim_pit_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pit_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic with_clear);
    @(negedge clk);
    tick = 1'b1;
    if (with_clear) begin bus_wr = 1'b1; bus_addr = 8'h1c; bus_wdata = 32'h2; end
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    logic hit;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(8'h20, v); chk("R1 count", v, 0);
    rd(8'h24, v); chk("R1 reload", v, 0);
    rd(8'h28, v); chk("R1 ctrl", v, 0);
    rd(8'h14, v); chk("R1 raw", v, 0);
    rd(8'h10, v); chk("R1 mask", v, 0);
    rd(8'h18, v); chk("R1 masked", v, 0);
    rd(8'h2c, v); chk("R11 unmapped", v, 0);
    wr(8'h10, 32'h2);
    rd(8'h10, v); chk("R9 mask readback", v, 2);

    for (int L = 0; L <= 6; L++) begin
      wr(8'h28, 0);
      wr(8'h24, L);
      rd(8'h24, v); chk("R2 reload store", v, L);
      wr(8'h28, 32'hffff_fffe);
      rd(8'h28, v); chk("R4 ctrl readback", v, 2);
      rd(8'h20, v); chk("R4 start copy", v, L);
      wr(8'h24, L + 7);
      rd(8'h24, v); chk("R3 reload locked", v, L);
      cnt = L;
      for (int k = 0; k < 2 * L + 4; k++) begin
        hit = 1'b0;
        if (L != 0) begin
          if (cnt <= 1) begin cnt = L; hit = 1'b1; end
          else cnt = cnt - 1;
        end
        pulse(1'b0);
        chk("R9 irq lag", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R9 irq follows", {31'b0, irq}, {31'b0, hit});
        rd(8'h20, v); chk(L == 0 ? "R7 zero reload" : "R5 R6 count", v, cnt);
        rd(8'h14, v); chk("R6 raw", v, hit ? 2 : 0);
        rd(8'h18, v); chk("R9 masked", v, hit ? 2 : 0);
        if (hit) begin
          wr(8'h1c, 32'h2);
          rd(8'h14, v); chk("R10 clear", v, 0);
        end
      end
      wr(8'h28, 2);
      rd(8'h20, v); chk("R4 no restart", v, cnt);
      wr(8'h28, 0);
      pulse(1'b0); pulse(1'b0); pulse(1'b0);
      rd(8'h20, v); chk("R8 hold", v, cnt);
      rd(8'h28, v); chk("R4 disabled", v, 0);
    end

    // expiry and clear in the same cycle
    wr(8'h24, 2);
    wr(8'h28, 2);
    pulse(1'b0);
    rd(8'h20, v); chk("R5 at one", v, 1);
    pulse(1'b1);
    rd(8'h14, v); chk("R10 set wins", v, 2);
    wr(8'h1c, 32'h1);
    rd(8'h14, v); chk("R10 no-op clear", v, 2);
    wr(8'h1c, 32'h2);
    rd(8'h14, v); chk("R10 clear", v, 0);
    wr(8'h10, 0);
    pulse(1'b0); pulse(1'b0);
    rd(8'h14, v); chk("R6 raw masked off", v, 2);
    rd(8'h18, v); chk("R9 masked off", v, 0);
    chk("R9 irq masked off", {31'b0, irq}, 0);
    rd(8'h20, v); chk("R6 reload", v, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule